// File: doc/BRIEF.md
# Link Transceiver Power-Up Configuration Sequencer

This block takes a serial-link transceiver from power-on reset to an operational state. Right after reset it looks at a permanent-programming status input. A programmed part asks a fuse-load engine for its stored settings through a request/acknowledge pair. It then waits until every internal ready indication has been stable for a set number of cycles, and declares itself ready. An unprogrammed part has to be configured from outside. A strap input picks the configuration path: either the in-band control channel or a two-wire management bus.

With the two-wire bus chosen, the sequencer waits for as long as it takes for a configuration-done flag from the bus side, then runs the same ready qualification. With the in-band channel chosen on an unprogrammed part, no high-speed link can ever come up. The sequencer then parks in a terminal unreachable state and flags it, instead of waiting forever. A fuse load that is never acknowledged is caught by a timeout and parks the block in an error state.

In the ready state both configuration paths are reported available. A synchronous soft reset returns the sequencer to the status check from any state.

Top module: `lnk_pwrup_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `state_o` is 0 (check) and every flag output is low.
- R2: In the check state with `fused_i` high, the next cycle shows `state_o` = 1 (load) with `fuse_req_o` high.
- R3: In the check state with `fused_i` low and `inband_sel_i` high, the next cycle shows `state_o` = 5 with `unreach_o` high. The block stays there whatever `cfg_done_i` and `int_rdy_i` do, until a reset.
- R4: In the check state with `fused_i` low and `inband_sel_i` low, the next cycle shows `state_o` = 2 (wait for configuration). The block stays there, ignoring later strap changes, until `cfg_done_i` is sampled high. It then shows `state_o` = 3 (power-up) one cycle later.
- R5: Suppose `fuse_ack_i` is sampled high during the k-th load cycle, where 1 <= k <= LOAD_TMO. The next cycle then shows `state_o` = 3, with `fuse_req_o` low and `fuse_err_o` low.
- R6: If no acknowledge comes within LOAD_TMO load cycles, the next cycle shows `state_o` = 6 with `fuse_err_o` high. This state is terminal, and a late acknowledge is ignored.
- R7: In the power-up state, `state_o` becomes 4 (ready) one cycle after the RDY_CYC-th consecutive sampled cycle in which every bit of `int_rdy_i` is high. Any low bit restarts the count.
- R8: In the ready state, `ready_o`, `bus_avail_o` and `inband_avail_o` are all high. The state is held even if `int_rdy_i` drops.
- R9: `soft_rst_i` sampled high in any state gives `state_o` = 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst_i | input | 1 | Synchronous restart to the status check |
| fused_i | input | 1 | Configuration permanently programmed |
| inband_sel_i | input | 1 | Strap: 1 in-band channel, 0 two-wire bus |
| fuse_ack_i | input | 1 | Fuse load finished |
| cfg_done_i | input | 1 | Configuration written over the two-wire bus |
| int_rdy_i | input | N_RDY | Internal ready indications |
| fuse_req_o | output | 1 | Fuse load request |
| ready_o | output | 1 | Transceiver operational |
| bus_avail_o | output | 1 | Two-wire path available |
| inband_avail_o | output | 1 | In-band path available |
| unreach_o | output | 1 | Part cannot be reached |
| fuse_err_o | output | 1 | Fuse load timed out |
| state_o | output | 3 | Current state code |

## Verification
All results are registered once. The path choice appears one cycle after the check cycle. The power-up state appears one cycle after the acknowledge or the done flag is sampled. Ready appears one cycle after the RDY_CYC-th qualifying sample, and the error state one cycle after the LOAD_TMO-th unacknowledged load cycle. The bench changes inputs 1 ns after a rising edge and reads outputs at that same point, after every single-cycle step. Each expectation therefore falls on a known edge count. The acknowledge latency is swept over every legal value, and the ready run length is tracked by a bench-side counter.

// File: rtl/lnk_seq_pkg.sv
package lnk_seq_pkg;

    typedef enum logic [2:0] {
        ST_CHECK   = 3'd0,
        ST_LOAD    = 3'd1,
        ST_WAITCFG = 3'd2,
        ST_PWRUP   = 3'd3,
        ST_READY   = 3'd4,
        ST_UNREACH = 3'd5,
        ST_FERR    = 3'd6
    } seq_st_e;

    typedef struct packed {
        logic fuse_req;
        logic ready;
        logic bus_avail;
        logic inband_avail;
        logic unreach;
        logic fuse_err;
    } seq_flags_t;

    function automatic seq_st_e entry_state(input logic fused, input logic inband);
        if (fused)       return ST_LOAD;
        else if (inband) return ST_UNREACH;
        else             return ST_WAITCFG;
    endfunction

    function automatic seq_flags_t flags_of(input seq_st_e s);
        seq_flags_t f;
        f              = '0;
        f.fuse_req     = (s == ST_LOAD);
        f.ready        = (s == ST_READY);
        f.bus_avail    = (s == ST_READY);
        f.inband_avail = (s == ST_READY);
        f.unreach      = (s == ST_UNREACH);
        f.fuse_err     = (s == ST_FERR);
        return f;
    endfunction

endpackage

// File: rtl/lnk_rdy_filter.sv
module lnk_rdy_filter #(
    parameter int N_RDY   = 3,
    parameter int RDY_CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [N_RDY-1:0] rdy_i,
    output logic             met_o
);
    localparam int CW = $clog2(RDY_CYC + 1);

    logic [CW-1:0] run_q;
    logic          all_hi;

    assign all_hi = &rdy_i;
    assign met_o  = en && all_hi && (run_q == CW'(RDY_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !en || !all_hi) begin
            run_q <= '0;
        end else if (run_q != CW'(RDY_CYC - 1)) begin
            run_q <= run_q + CW'(1);
        end
    end

    // R7
    run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run_q < CW'(RDY_CYC));

    // R7
    run_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !all_hi) |=> (run_q == '0));

endmodule

// File: rtl/lnk_load_timer.sv
module lnk_load_timer #(
    parameter int LOAD_TMO = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic ack_i,
    output logic expire_o
);
    localparam int CW = $clog2(LOAD_TMO + 1);

    logic [CW-1:0] tmr_q;

    assign expire_o = en && !ack_i && (tmr_q == CW'(LOAD_TMO - 1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            tmr_q <= '0;
        end else if (tmr_q != CW'(LOAD_TMO - 1)) begin
            tmr_q <= tmr_q + CW'(1);
        end
    end

    // R6
    tmr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        tmr_q < CW'(LOAD_TMO));

endmodule

// File: rtl/lnk_pwrup_seq.sv
module lnk_pwrup_seq
    import lnk_seq_pkg::*;
#(
    parameter int N_RDY    = 3,
    parameter int RDY_CYC  = 4,
    parameter int LOAD_TMO = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst_i,
    input  logic             fused_i,
    input  logic             inband_sel_i,
    input  logic             fuse_ack_i,
    input  logic             cfg_done_i,
    input  logic [N_RDY-1:0] int_rdy_i,
    output logic             fuse_req_o,
    output logic             ready_o,
    output logic             bus_avail_o,
    output logic             inband_avail_o,
    output logic             unreach_o,
    output logic             fuse_err_o,
    output logic [2:0]       state_o
);
    seq_st_e    state_q, state_d;
    seq_flags_t flags;
    logic       rdy_met;
    logic       load_expire;

    lnk_rdy_filter #(.N_RDY(N_RDY), .RDY_CYC(RDY_CYC)) u_rdy_filter (
        .clk   (clk),
        .rst   (rst),
        .en    (state_q == ST_PWRUP),
        .rdy_i (int_rdy_i),
        .met_o (rdy_met)
    );

    lnk_load_timer #(.LOAD_TMO(LOAD_TMO)) u_load_timer (
        .clk      (clk),
        .rst      (rst),
        .en       (state_q == ST_LOAD),
        .ack_i    (fuse_ack_i),
        .expire_o (load_expire)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_CHECK:   state_d = entry_state(fused_i, inband_sel_i);
            ST_LOAD: begin
                if (fuse_ack_i)       state_d = ST_PWRUP;
                else if (load_expire) state_d = ST_FERR;
            end
            ST_WAITCFG: if (cfg_done_i) state_d = ST_PWRUP;
            ST_PWRUP:   if (rdy_met)    state_d = ST_READY;
            default:    state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst_i) state_q <= ST_CHECK;
        else                   state_q <= state_d;
    end

    assign flags          = flags_of(state_q);
    assign fuse_req_o     = flags.fuse_req;
    assign ready_o        = flags.ready;
    assign bus_avail_o    = flags.bus_avail;
    assign inband_avail_o = flags.inband_avail;
    assign unreach_o      = flags.unreach;
    assign fuse_err_o     = flags.fuse_err;
    assign state_o        = state_q;

    // R7
    ready_needs_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> $past(&int_rdy_i));

    // R9
    soft_rst_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst_i |=> (state_o == 3'd0));

    // R3
    unreach_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (unreach_o && !soft_rst_i) |=> unreach_o);

    // R2
    load_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fuse_req_o) |-> $past(fused_i));

    // R6
    fuse_err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fuse_err_o) |-> ($past(fuse_req_o) && !$past(fuse_ack_i)));

    // R8
    ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ready_o && !soft_rst_i) |=> ready_o);

endmodule

// File: tb/lnk_pwrup_seq_bench.sv
`timescale 1ns/1ps
module lnk_pwrup_seq_bench;
    localparam int N_RDY    = 3;
    localparam int RDY_CYC  = 4;
    localparam int LOAD_TMO = 8;
    localparam logic [N_RDY-1:0] ALL_HI = '1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic soft_rst_i = 1'b0;
    logic fused_i = 1'b0;
    logic inband_sel_i = 1'b0;
    logic fuse_ack_i = 1'b0;
    logic cfg_done_i = 1'b0;
    logic [N_RDY-1:0] int_rdy_i = '0;
    logic fuse_req_o, ready_o, bus_avail_o, inband_avail_o, unreach_o, fuse_err_o;
    logic [2:0] state_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    lnk_pwrup_seq #(.N_RDY(N_RDY), .RDY_CYC(RDY_CYC), .LOAD_TMO(LOAD_TMO)) u_lnk_pwrup_seq (
        .clk(clk), .rst(rst), .soft_rst_i(soft_rst_i), .fused_i(fused_i),
        .inband_sel_i(inband_sel_i), .fuse_ack_i(fuse_ack_i), .cfg_done_i(cfg_done_i),
        .int_rdy_i(int_rdy_i), .fuse_req_o(fuse_req_o), .ready_o(ready_o),
        .bus_avail_o(bus_avail_o), .inband_avail_o(inband_avail_o),
        .unreach_o(unreach_o), .fuse_err_o(fuse_err_o), .state_o(state_o)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int flag_word();
        return {26'd0, fuse_req_o, ready_o, bus_avail_o, inband_avail_o, unreach_o, fuse_err_o};
    endfunction

    // reset, leave the check state with the given straps; returns at the entry state
    task automatic enter(input logic fz, input logic strap);
        fused_i = fz; inband_sel_i = strap;
        rst = 1'b1;
        step(2);
        chk("R1 state in reset", state_o, 0);
        rst = 1'b0;
        chk("R1 state after reset", state_o, 0);
        chk("R1 flags after reset", flag_word(), 0);
        step(1);
    endtask

    initial begin
        int run;
        logic [N_RDY-1:0] v;
        step(1);

        // R2 R3 R4: entry state over every strap combination
        for (int f = 0; f < 2; f++) begin
            for (int s = 0; s < 2; s++) begin
                int exp_st;
                exp_st = (f != 0) ? 1 : ((s != 0) ? 5 : 2);
                enter(f[0], s[0]);
                chk(f != 0 ? "R2 entry" : (s != 0 ? "R3 entry" : "R4 entry"), state_o, exp_st);
                chk("R2 fuse_req", fuse_req_o, f);
                chk("R3 unreach flag", unreach_o, (f == 0 && s != 0) ? 1 : 0);
            end
        end

        // R4: wait loop ignores strap, leaves on cfg_done
        enter(1'b0, 1'b0);
        inband_sel_i = 1'b1;
        int_rdy_i = ALL_HI;
        for (int i = 0; i < 3; i++) begin
            step(1);
            chk("R4 waiting", state_o, 2);
        end
        cfg_done_i = 1'b1;
        step(1);
        cfg_done_i = 1'b0;
        chk("R4 to power-up", state_o, 3);

        // R7: ready qualification with glitches on each bit
        run = 0;
        for (int i = 0; i < 40; i++) begin
            v = ALL_HI;
            if (i < 16 && (i % 4) == 3) v[(i / 4) % N_RDY] = 1'b0;
            int_rdy_i = v;
            step(1);
            run = (v == ALL_HI) ? run + 1 : 0;
            chk("R7 qualification", state_o, (run >= RDY_CYC) ? 4 : 3);
            if (run >= RDY_CYC) break;
        end
        chk("R8 ready flags", flag_word(), 6'b011100);
        int_rdy_i = '0;
        step(3);
        chk("R8 ready held", state_o, 4);
        chk("R8 ready_o held", ready_o, 1);

        // R9 from ready
        fused_i = 1'b1;
        soft_rst_i = 1'b1;
        step(1);
        soft_rst_i = 1'b0;
        chk("R9 soft reset from ready", state_o, 0);
        step(1);
        chk("R9 then load", state_o, 1);

        // R5: acknowledge latency sweep
        for (int k = 0; k < LOAD_TMO; k++) begin
            enter(1'b1, 1'b0);
            for (int j = 0; j < k; j++) begin
                step(1);
                chk("R5 still loading", state_o, 1);
            end
            fuse_ack_i = 1'b1;
            step(1);
            fuse_ack_i = 1'b0;
            chk("R5 ack -> power-up", state_o, 3);
            chk("R5 no request/error", {fuse_req_o, fuse_err_o}, 0);
        end

        // R6: timeout
        enter(1'b1, 1'b0);
        step(LOAD_TMO - 1);
        chk("R6 last load cycle", state_o, 1);
        step(1);
        chk("R6 timeout state", state_o, 6);
        chk("R6 error flag", fuse_err_o, 1);
        fuse_ack_i = 1'b1;
        step(2);
        fuse_ack_i = 1'b0;
        chk("R6 late ack ignored", state_o, 6);
        soft_rst_i = 1'b1;
        step(1);
        soft_rst_i = 1'b0;
        chk("R9 soft reset from error", state_o, 0);

        // R3: unreachable is terminal
        enter(1'b0, 1'b1);
        cfg_done_i = 1'b1;
        int_rdy_i = ALL_HI;
        step(RDY_CYC + 2);
        chk("R3 still unreachable", state_o, 5);
        chk("R3 not ready", ready_o, 0);
        cfg_done_i = 1'b0;
        soft_rst_i = 1'b1;
        step(1);
        soft_rst_i = 1'b0;
        chk("R9 soft reset from unreachable", state_o, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule